// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block turns a digital "supply above threshold" indication from an analog comparator into an active-low system reset. Software controls it through two 8-bit registers. The control register holds a monitor enable and shows the live supply status. The source register holds the select that arms the monitor as a reset cause, together with a read-only power-on flag. When the monitor is both enabled and selected, a low supply holds the system in reset. The reset is released a fixed number of cycles after the supply recovers.

The monitor needs a turn-on time after it is enabled. That time is counted in clock cycles from the write that enables it. Arming the select before the count has run out produces a spurious reset, so software must enable the monitor, wait, and only then select it. A power-on reset forces the enable on and sets the power-on flag. Any later reset leaves the enable alone and clears the flag, so software can tell a cold start from a warm one.

A software reset request enters as a plain input pulse. It produces a stretched reset of the same length as the other causes.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is low. After `por_n` rises, `sys_rst_n` stays low for exactly MIN_RST_CYCLES clock periods and then goes high. After a power-on reset the control register reads 0xC0 once the supply is high, and the source register reads 0x01.
- R2: Control register (`reg_addr`=0): bit 7 is the enable and bits 5..0 read 0. Source register (`reg_addr`=1): bit 1 is the select, bit 0 is the power-on flag, and bits 7..2 read 0. Writes to the bits that read 0 have no effect.
- R3: Control bit 6 shows the supply input after a two-flop synchronizer, with 1 meaning above threshold. A write cannot change it. A change on the input appears in the read value after the second rising edge.
- R4: A power-on reset forces the enable to 1 and clears the select. Only a control write changes the enable, so a software reset or a monitor-caused reset leaves it as it was.
- R5: A low supply causes no reset unless the enable and the select are both 1.
- R6: While the enable and the select are 1 and the synchronized status is 0, `sys_rst_n` is held low, starting one edge after the status falls. After the status returns to 1, `sys_rst_n` stays low for MIN_RST_CYCLES more periods.
- R7: A write of select=1 while the monitor is disabled or not yet stable triggers a reset. `sys_rst_n` goes low after that write edge and stays low for MIN_RST_CYCLES periods. The select is still set.
- R8: The power-on flag is 1 after a power-on reset. It is cleared by any other reset cause: a software reset, a spurious select, or a low-supply hold.
- R9: A one-cycle `sw_rst_req` drives `sys_rst_n` low for MIN_RST_CYCLES periods after the edge that samples it. The enable and the select are kept.
- R10: The monitor counts as stable when TURNON_CYCLES edges have passed since the edge of the write that took the enable from 0 to 1 (or since power-on release). A select written on edge TURNON_CYCLES is spurious; one written on edge TURNON_CYCLES+1 is not. Clearing the enable resets the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sw_rst_req | input | 1 | Software reset request, sampled on the rising edge |
| supply_ok_raw | input | 1 | Comparator output, 1 = supply above threshold, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = control, 1 = source |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
A register write takes effect at the edge that samples it, so the read value and any reset it triggers are visible at the following falling edge. A supply change takes two edges to reach the status bit and a third edge to pull the reset low. A stretched reset stays low for exactly MIN_RST_CYCLES periods after the last edge on which a cause was seen. The bench drives its inputs just after a rising edge. It compares the reset output and the read data against its behavioural model at every falling edge. The directed checks are placed at the cycles these counts give, one cycle before and one cycle after each expected change.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
   localparam int unsigned REG_W         = 8;
   localparam logic        ADDR_CTRL     = 1'b0;
   localparam logic        ADDR_SRC      = 1'b1;
   localparam int unsigned CTRL_EN_BIT   = 7;
   localparam int unsigned CTRL_STAT_BIT = 6;
   localparam int unsigned SRC_SEL_BIT   = 1;
   localparam int unsigned SRC_FLAG_BIT  = 0;

   typedef struct packed {
      logic en;
      logic sel;
      logic flag;
   } supmon_state_t;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("supmon_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/supmon_turnon.sv
module supmon_turnon #(
   parameter int unsigned CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   output logic stable
);
   if (CYCLES == 0) begin : g_instant
      assign stable = en;
   end else begin : g_count
      localparam int unsigned W = $clog2(CYCLES + 1);
      localparam logic [W-1:0] LIMIT = W'(CYCLES);
      logic [W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt <= '0;
         else if (restart || !en)  cnt <= '0;
         else if (cnt != LIMIT)    cnt <= cnt + 1'b1;
      end

      assign stable = en && (cnt == LIMIT);

      a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> !stable);
   end
endmodule

// File: rtl/supmon_stretch.sv
module supmon_stretch #(
   parameter int unsigned MIN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cause,
   output logic rst_n_o
);
   if (MIN < 1) begin : g_bad_min
      $error("supmon_stretch: MIN must be at least 1");
   end

   localparam int unsigned W = $clog2(MIN + 1);
   localparam logic [W-1:0] LOAD = W'(MIN);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= LOAD;
      else if (cause)     cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign rst_n_o = (cnt == '0);

   a_r6_cause_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      cause |=> !rst_n_o);
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
   import supmon_pkg::*;
#(
   parameter int unsigned TURNON_CYCLES  = 64,
   parameter int unsigned MIN_RST_CYCLES = 16,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sw_rst_req,
   input  logic             supply_ok_raw,
   input  logic             reg_wr,
   input  logic             reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sys_rst_n
);
   if (SYNC_STAGES != 2) begin : g_bad_sync
      $error("supmon_rst_ctrl: the status latency is defined for two stages");
   end
   if (MIN_RST_CYCLES < 1) begin : g_bad_min
      $error("supmon_rst_ctrl: MIN_RST_CYCLES must be at least 1");
   end

   supmon_state_t st;
   logic          supply_ok;
   logic          stable;
   logic          ctrl_wr, src_wr;
   logic          restart;
   logic          early_sel, low_hold, cause;
   logic          wdata_unused;

   assign wdata_unused = ^{reg_wdata[CTRL_STAT_BIT:SRC_SEL_BIT+1], reg_wdata[SRC_FLAG_BIT]};

   supmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (supply_ok_raw),
      .q     (supply_ok)
   );

   assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
   assign src_wr  = reg_wr && (reg_addr == ADDR_SRC);
   assign restart = ctrl_wr && reg_wdata[CTRL_EN_BIT] && !st.en;

   supmon_turnon #(.CYCLES(TURNON_CYCLES)) u_turnon (
      .clk     (clk),
      .rst_n   (por_n),
      .en      (st.en),
      .restart (restart),
      .stable  (stable)
   );

   assign early_sel = src_wr && reg_wdata[SRC_SEL_BIT] && !stable;
   assign low_hold  = st.en && st.sel && !supply_ok;
   assign cause     = low_hold || early_sel || sw_rst_req;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st.en   <= 1'b1;
         st.sel  <= 1'b0;
         st.flag <= 1'b1;
      end else begin
         if (ctrl_wr) st.en  <= reg_wdata[CTRL_EN_BIT];
         if (src_wr)  st.sel <= reg_wdata[SRC_SEL_BIT];
         if (cause)   st.flag <= 1'b0;
      end
   end

   supmon_stretch #(.MIN(MIN_RST_CYCLES)) u_stretch (
      .clk     (clk),
      .rst_n   (por_n),
      .cause   (cause),
      .rst_n_o (sys_rst_n)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CTRL) begin
         reg_rdata[CTRL_EN_BIT]   = st.en;
         reg_rdata[CTRL_STAT_BIT] = supply_ok;
      end else begin
         reg_rdata[SRC_SEL_BIT]  = st.sel;
         reg_rdata[SRC_FLAG_BIT] = st.flag;
      end
   end

   a_r4_enable_kept: assert property (@(posedge clk) disable iff (!por_n)
      !ctrl_wr |=> $stable(st.en));

   a_r7_early_select: assert property (@(posedge clk) disable iff (!por_n)
      (src_wr && reg_wdata[SRC_SEL_BIT] && !(st.en && stable)) |=> !sys_rst_n);

   a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!por_n)
      sw_rst_req |=> !st.flag);

   a_r9_sw_reset: assert property (@(posedge clk) disable iff (!por_n)
      sw_rst_req |=> !sys_rst_n);

   a_r5_reset_has_cause: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sys_rst_n) |-> $past(cause));
endmodule

// File: tb/sim_supmon_rst_ctrl.sv
module sim_supmon_rst_ctrl;
   localparam int TON = 12;
   localparam int M   = 5;

   logic       clk = 1'b0;
   logic       por_n;
   logic       sw_rst_req = 1'b0;
   logic       supply_ok_raw = 1'b1;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sys_rst_n;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   supmon_rst_ctrl #(.TURNON_CYCLES(TON), .MIN_RST_CYCLES(M), .SYNC_STAGES(2)) u0 (
      .clk           (clk),
      .por_n         (por_n),
      .sw_rst_req    (sw_rst_req),
      .supply_ok_raw (supply_ok_raw),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .sys_rst_n     (sys_rst_n)
   );

   // behavioural reference model
   int m_s1 = 0, m_s2 = 0, m_en = 1, m_sel = 0, m_flag = 1, m_on = 0, m_cnt = M;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_s1 = 0; m_s2 = 0; m_en = 1; m_sel = 0; m_flag = 1; m_on = 0; m_cnt = M;
      end else begin
         int is_stable, spur, cause, n_on;
         is_stable = (m_en != 0) && (m_on >= TON);
         spur  = reg_wr && reg_addr && reg_wdata[1] && !is_stable;
         cause = ((m_en != 0) && (m_sel != 0) && (m_s2 == 0)) || sw_rst_req || spur;
         n_on  = m_on;
         if (reg_wr && !reg_addr && !reg_wdata[7]) n_on = 0;
         else if (reg_wr && !reg_addr && m_en == 0) n_on = 0;
         else if (m_en != 0 && m_on < TON) n_on = m_on + 1;
         m_on = n_on;
         if (reg_wr && !reg_addr) m_en = reg_wdata[7];
         if (reg_wr && reg_addr)  m_sel = reg_wdata[1];
         if (cause) m_flag = 0;
         if (cause) m_cnt = M;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         m_s2 = m_s1;
         m_s1 = supply_ok_raw;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int exp_rd;
      chk("R6 per-cycle sys_rst_n", int'(sys_rst_n), (m_cnt == 0) ? 1 : 0);
      exp_rd = reg_addr ? ((m_sel << 1) | m_flag) : ((m_en << 7) | (m_s2 << 6));
      chk("R1 per-cycle reg_rdata", int'(reg_rdata), exp_rd);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=%0d expected<20000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic rd_chk(input string tag, input logic a, input int exp);
      reg_addr = a;
      @(negedge clk);
      chk(tag, int'(reg_rdata), exp);
      @(posedge clk); #2;
   endtask

   initial begin
      por_n = 1'b0;
      step(3);
      chk("R1 reset low during por", int'(sys_rst_n), 0);
      por_n = 1'b1;
      step(M - 1);
      chk("R1 still low before stretch end", int'(sys_rst_n), 0);
      step(1);
      chk("R1 released after stretch", int'(sys_rst_n), 1);
      rd_chk("R1 control after por", 1'b0, 8'hC0);
      rd_chk("R8 source after por", 1'b1, 8'h01);

      wr(1'b0, 8'hBF);
      rd_chk("R2 reserved control bits read 0", 1'b0, 8'hC0);
      wr(1'b0, 8'h7F);
      rd_chk("R3 status not writable", 1'b0, 8'h40);
      wr(1'b1, 8'hFD);
      rd_chk("R2 reserved source bits ignored", 1'b1, 8'h01);

      // early select right after enabling
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h02);
      chk("R7 early select resets", int'(sys_rst_n), 0);
      rd_chk("R8 flag cleared by spurious reset", 1'b1, 8'h02);
      step(M + 2);
      chk("R7 spurious reset released", int'(sys_rst_n), 1);

      // turn-on boundary: one edge short
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h00);
      wr(1'b0, 8'h80);
      step(TON - 1);
      wr(1'b1, 8'h02);
      chk("R10 select one edge early resets", int'(sys_rst_n), 0);
      step(M + 2);
      // turn-on boundary: exactly stable
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h00);
      wr(1'b0, 8'h80);
      step(TON);
      wr(1'b1, 8'h02);
      chk("R10 select when stable no reset", int'(sys_rst_n), 1);
      step(2);
      chk("R10 still no reset", int'(sys_rst_n), 1);

      // low supply hold
      supply_ok_raw = 1'b0;
      step(2);
      chk("R6 no reset before sync latency", int'(sys_rst_n), 1);
      step(1);
      chk("R6 reset held on low supply", int'(sys_rst_n), 0);
      step(10);
      chk("R6 reset still held", int'(sys_rst_n), 0);
      rd_chk("R3 status shows low supply", 1'b0, 8'h80);
      supply_ok_raw = 1'b1;
      step(M + 1);
      chk("R6 held until stretch end", int'(sys_rst_n), 0);
      step(1);
      chk("R6 released after recovery", int'(sys_rst_n), 1);

      // no reset without enable and select
      wr(1'b0, 8'h00);
      supply_ok_raw = 1'b0;
      step(6);
      chk("R5 disabled monitor no reset", int'(sys_rst_n), 1);
      supply_ok_raw = 1'b1;
      step(3);
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h00);
      supply_ok_raw = 1'b0;
      step(6);
      chk("R5 unselected monitor no reset", int'(sys_rst_n), 1);
      supply_ok_raw = 1'b1;
      step(3);

      // software reset keeps enable and select
      step(TON);
      wr(1'b1, 8'h02);
      wr(1'b0, 8'h00);
      sw_rst_req = 1'b1;
      step(1);
      sw_rst_req = 1'b0;
      chk("R9 software reset asserts", int'(sys_rst_n), 0);
      rd_chk("R4 enable kept through software reset", 1'b0, 8'h40);
      rd_chk("R9 select kept, R8 flag cleared", 1'b1, 8'h02);
      step(M + 2);
      chk("R9 software reset released", int'(sys_rst_n), 1);

      // second power-on reset
      por_n = 1'b0;
      step(2);
      chk("R1 por asserts reset", int'(sys_rst_n), 0);
      rd_chk("R4 por forces enable", 1'b0, 8'h80);
      por_n = 1'b1;
      step(M + 3);
      rd_chk("R8 flag set again by por", 1'b1, 8'h01);
      rd_chk("R4 enable 1 after por", 1'b0, 8'hC0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule